// File: doc/BRIEF.md
# Composite clock selector and divider

This block builds one output clock from four candidate source clocks. A 32-bit control word selects a source, sets an optional pre-divider that sits in the path only when source 3 is selected, and sets a post-divider that every source passes through. The output frequency is the selected source frequency divided by the pre-divider ratio (source 3 only) and then by the post-divider ratio.

Software writes the control word through a simple write port with byte enables, running on a separate register clock, and reads it back at all times. A partial write updates only the enabled byte lanes, so the divider fields can be changed without touching the source select. Each divider stage switches to a new ratio only at the end of its current output period, which keeps runt pulses off the output. Division is counter-based and runs directly on the selected source clock.

Top module: `ccd_clk_gen`

## Requirements
- R1: After reset the control word reads 0, source 0 is selected, both dividers are bypassed and the output follows source 0.
- R2: Control bits 17:16 select the source clock: value k routes source k into the divider path.
- R3: Control bits 5:4 hold the post-divider; the output period is (value + 1) times the period of the post-divider's input.
- R4: Control bits 12:8 hold the pre-divider; when the select equals 3 the source period is multiplied by (value + 1) before the post-divider.
- R5: When the select is 0, 1 or 2, the pre-divider field has no effect on the output.
- R6: A write updates only the byte lanes whose enable bit is set (bit i covers data bits 8i+7:8i); disabled lanes keep their previous value.
- R7: Control bits outside the three fields read back as written and have no effect on the output.
- R8: A ratio of 1 passes the stage input through unchanged; a ratio N above 1 gives a high phase of floor(N/2) input periods, so even ratios give 50% duty and odd ratios a high phase one input period shorter than the low phase.
- R9: A divider stage adopts a new ratio only at the end of its current output period, so with the source unchanged no output high pulse is shorter than the smaller of the old and new high times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_clk_i | input | 4 | Candidate source clocks, index k is source k |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_be_i | input | 4 | Byte-lane enables for the write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current control word |
| clk_o | output | 1 | Divided output clock |

## Verification
A register write is visible on the read port one register clock edge after the strobe, and the bench compares the read value at the following falling edge against a byte-lane model of the control word. A new divider setting reaches the output only at the end of the current output period of each stage, so after every write the monitor lets three output rising edges go by before it times one full period and one high phase and compares them with the values the driver queued. During that settling window, for writes that leave the source unchanged, the monitor also records the shortest high pulse and compares it with the smaller of the old and new high times.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned SEL_LSB  = 16;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned PRE_LSB  = 8;
  localparam int unsigned PRE_W    = 5;
  localparam int unsigned POST_LSB = 4;
  localparam int unsigned POST_W   = 2;
  localparam int unsigned NUM_SRC  = 1 << SEL_W;
  localparam logic [SEL_W-1:0] PRE_SRC = SEL_W'(NUM_SRC - 1);

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
  } ccd_cfg_t;

  function automatic ccd_cfg_t unpack_cfg(input logic [CTRL_W-1:0] w);
    ccd_cfg_t c;
    c.sel  = w[SEL_LSB  +: SEL_W];
    c.pre  = w[PRE_LSB  +: PRE_W];
    c.post = w[POST_LSB +: POST_W];
    return c;
  endfunction
endpackage

// File: rtl/ccd_regs.sv
module ccd_regs #(
  parameter int unsigned DW = 32,
  localparam int unsigned BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [BW-1:0] wr_be_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] ctrl_o
);
  logic [DW-1:0] ctrl_q;

  for (genvar g = 0; g < BW; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q[g*8 +: 8] <= '0;
      else if (wr_en_i && wr_be_i[g]) ctrl_q[g*8 +: 8] <= wr_data_i[g*8 +: 8];
    end

    AST_LANE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(wr_en_i && wr_be_i[g])) |=> $stable(ctrl_q[g*8 +: 8])); // R6
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ccd_src_mux.sv
module ccd_src_mux #(
  parameter int unsigned NSRC = 4,
  localparam int unsigned SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] src_clk_i,
  input  logic [SW-1:0]   sel_i,
  output logic            clk_o
);
  always_comb begin
    clk_o = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel_i == SW'(i)) clk_o = src_clk_i[i];
    end
  end
endmodule

// File: rtl/ccd_div_stage.sv
module ccd_div_stage #(
  parameter int unsigned RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ratio_m1_i,
  output logic          clk_o
);
  logic [RW-1:0] act_q, cnt_q;
  logic          div_q;
  logic [RW:0]   hi_cur, hi_new, cnt_nx;
  logic          wrap;

  assign wrap   = (cnt_q == act_q);
  assign hi_cur = ({1'b0, act_q} + 1'b1) >> 1;
  assign hi_new = ({1'b0, ratio_m1_i} + 1'b1) >> 1;
  assign cnt_nx = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (wrap) begin
      // period boundary: adopt pending ratio
      act_q <= ratio_m1_i;
      cnt_q <= '0;
      div_q <= (hi_new != '0) && (ratio_m1_i != '0);
    end else begin
      cnt_q <= cnt_q + 1'b1;
      div_q <= (cnt_nx < hi_cur);
    end
  end

  // ratio 1 bypasses the counter
  assign clk_o = (act_q == '0) ? clk_i : div_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_q); // R8
  AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != act_q) |=> $stable(act_q)); // R9
  AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_q) |-> (cnt_q == '0)); // R8
endmodule

// File: rtl/ccd_clk_gen.sv
module ccd_clk_gen
  import ccd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_be_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic              clk_o
);
  logic [CTRL_W-1:0] ctrl;
  ccd_cfg_t          cfg;
  logic              sel_clk, pre_clk;
  logic [PRE_W-1:0]  pre_ratio;

  ccd_regs #(.DW(CTRL_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_be_i   (wr_be_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl)
  );

  assign cfg       = unpack_cfg(ctrl);
  assign rd_data_o = ctrl;

  ccd_src_mux #(.NSRC(NUM_SRC)) u_mux (
    .src_clk_i (src_clk_i),
    .sel_i     (cfg.sel),
    .clk_o     (sel_clk)
  );

  // pre-divider sits in the path for one source only
  assign pre_ratio = (cfg.sel == PRE_SRC) ? cfg.pre : '0;

  ccd_div_stage #(.RW(PRE_W)) u_pre (
    .clk_i      (sel_clk),
    .rst_ni     (rst_ni),
    .ratio_m1_i (pre_ratio),
    .clk_o      (pre_clk)
  );

  ccd_div_stage #(.RW(POST_W)) u_post (
    .clk_i      (pre_clk),
    .rst_ni     (rst_ni),
    .ratio_m1_i (cfg.post),
    .clk_o      (clk_o)
  );

  AST_PRE_IDLE_OFF_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.sel != PRE_SRC) |-> (pre_ratio == '0)); // R5
endmodule

// File: tb/tb_ccd_clk_gen.sv
`timescale 1ns/1ps
module tb_ccd_clk_gen;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  src = 4'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clk_out;

  always #4 clk = ~clk;       // 125 MHz
  always #5  src[0] = ~src[0]; // 10 ns
  always #7  src[1] = ~src[1]; // 14 ns
  always #11 src[2] = ~src[2]; // 22 ns
  always #2  src[3] = ~src[3]; // 4 ns

  ccd_clk_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src), .wr_en_i(wr_en),
    .wr_be_i(wr_be), .wr_data_i(wr_data), .rd_data_o(rd_data), .clk_o(clk_out)
  );

  typedef struct {
    string  tag;
    longint period;
    longint high;
    longint min_hi;
    bit     chk_min;
  } item_t;

  item_t  sb_q[$];
  int     n_cmp = 0, n_bad = 0, issued = 0, done_cnt = 0;
  bit     finished = 0;
  logic [31:0] model = '0;
  longint prev_high = 5;
  logic [1:0]  prev_sel = 2'd0;
  int     src_per [4] = '{10, 14, 22, 4};

  task automatic check(input string tag, input longint got, input longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver: write, check readback, queue expected clock shape
  task automatic cfg(input string tag, input bit do_wr, input logic [3:0] be,
                     input logic [31:0] data);
    item_t it;
    int sel, npre, npost;
    longint t;
    if (do_wr) begin
      @(negedge clk);
      wr_en = 1'b1; wr_be = be; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_be = 4'h0;
      for (int b = 0; b < 4; b++) if (be[b]) model[b*8 +: 8] = data[b*8 +: 8];
      check({tag, " readback"}, rd_data, model);
    end
    sel   = model[17:16];
    npre  = (sel == 3) ? int'(model[12:8]) + 1 : 1;
    npost = int'(model[5:4]) + 1;
    t     = src_per[sel];
    it.tag    = tag;
    it.period = t * npre * npost;
    if (npost > 1)     it.high = (npost / 2) * npre * t;
    else if (npre > 1) it.high = (npre / 2) * t;
    else               it.high = t / 2;
    it.min_hi  = (prev_high < it.high) ? prev_high : it.high;
    it.chk_min = (model[17:16] == prev_sel);
    prev_high  = it.high;
    prev_sel   = model[17:16];
    sb_q.push_back(it);
    issued++;
    wait (done_cnt == issued);
  endtask

  // monitor: settle past the boundary, then time one period
  initial begin
    forever begin
      item_t it;
      longint tr, t1, t2, t3, minh;
      wait (sb_q.size() > 0);
      minh = 64'h7fff_ffff;
      for (int k = 0; k < 3; k++) begin
        @(posedge clk_out); tr = $time;
        @(negedge clk_out); if ($time - tr < minh) minh = $time - tr;
      end
      @(posedge clk_out); t1 = $time;
      @(negedge clk_out); t2 = $time;
      @(posedge clk_out); t3 = $time;
      it = sb_q.pop_front();
      check({it.tag, " period"}, t3 - t1, it.period);
      check({it.tag, " high"},   t2 - t1, it.high);
      if (it.chk_min) check({"R9 min pulse in ", it.tag}, (minh >= it.min_hi) ? 1 : 0, 1);
      done_cnt++;
    end
  end

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset readback", rd_data, 32'h0);
    rst_n = 1'b1;
    cfg("R1 reset src0",            1'b0, 4'h0, 32'h0);
    cfg("R2 src1",                  1'b1, 4'hF, 32'h0001_0000);
    cfg("R3 src2 div2",             1'b1, 4'hF, 32'h0002_0010);
    cfg("R8 src0 div3 odd",         1'b1, 4'hF, 32'h0000_0020);
    cfg("R5 src0 pre ignored",      1'b1, 4'hF, 32'h0000_1F30);
    cfg("R8 src3 passthrough",      1'b1, 4'hF, 32'h0003_0000);
    cfg("R4 src3 pre5",             1'b1, 4'hF, 32'h0003_0400);
    cfg("R6 lanes0-1 keep sel",     1'b1, 4'h3, 32'h0000_1F30);
    cfg("R9 src3 shrink",           1'b1, 4'h3, 32'h0000_0210);
    cfg("R7 spare bits src2",       1'b1, 4'hF, 32'hF0A2_C000);
    cfg("R4 src3 pre32",            1'b1, 4'hF, 32'h0003_1F00);
    finish_run();
  end
endmodule